// File: doc/BRIEF.md
# Lockable Software Watchdog Timer

This block is a software watchdog timer. Its settings sit in one configuration register that software may read at any time but may write only once after reset. The register holds a 16-bit reload count, an enable bit and a freeze-enable bit. The watchdog leaves reset already running. Software that wants it off must clear the enable bit in its one permitted write.

While enabled, a down-counter advances on each clock cycle in which the tick qualifier is high. Software restarts the count by writing two key bytes in order to a service port. If the count runs out first, the block pulses a timeout output for one cycle and starts again from the reload value. A debug-halt input can pause the count when the freeze-enable bit is set.

An asynchronous active-low reset enters a two-stage synchronizer. Its release takes effect two clock edges after `rst_n` rises.

Top module: `wdog_lock_top`

## Requirements
- R1: After reset the read port shows 0x1FFFF. Bits [15:0] are the reload count (0xFFFF), bit 16 is enable (1) and bit 17 is freeze-enable (0).
- R2: The read port always shows the register. The first configuration write after reset is stored, and the counter is loaded with the new reload count at the same edge.
- R3: Every configuration write after the first one, until the next reset, leaves the register unchanged.
- R4: While enabled, each qualified tick decrements the count. The tick that finds the count at zero reloads it and raises timeout for exactly the following cycle. A timeout therefore falls R+1 qualified ticks after a load of value R.
- R5: With enable at 0 the counter holds the reload count and timeout stays low.
- R6: With freeze-enable at 1, a tick that arrives while dbg_halt is high is ignored.
- R7: With freeze-enable at 0, dbg_halt has no effect on counting.
- R8: A service write of 0x5A followed by a service write of 0xA5 reloads the counter at the edge of the 0xA5 write. Other cycles may fall between the two writes. This reload overrides a tick at the same edge.
- R9: A service write of any value other than the expected key clears the sequence. A 0xA5 write with no pending 0x5A does nothing. A repeated 0x5A keeps the sequence pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 18 | Configuration write data |
| cfg_rd_data | output | 18 | Configuration register contents |
| svc_wr_en | input | 1 | Service port write strobe |
| svc_data | input | 8 | Service key byte |
| dbg_halt | input | 1 | Debug halt indication |
| tick_en | input | 1 | Count qualifier |
| timeout | output | 1 | One-cycle expiry pulse |

## Verification
A configuration write shows on `cfg_rd_data` in the cycle after its clock edge. A timeout is registered, so it appears in the cycle after the edge whose tick found the count at zero. Service and configuration reloads take effect at their own edge and so move the next timeout. The bench drives inputs just after a falling edge and advances a reference model for the coming rising edge. It compares both outputs at the next falling edge, so each result is sampled one register stage after its cause. After every reset the bench waits out the two synchronizer stages before starting the model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int SVC_W     = 8;
  localparam int KEY_FIRST = 8'h5A;
  localparam int KEY_SECOND = 8'hA5;

  typedef enum logic {
    SVC_IDLE  = 1'b0,
    SVC_ARMED = 1'b1
  } svc_state_e;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg #(
  parameter int CNT_W = 16,
  localparam int CFG_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] rd_data,
  output logic             accept,
  output logic             locked,
  output logic [CNT_W-1:0] reload,
  output logic             run_en,
  output logic             frz_en
);
  localparam logic [CFG_W-1:0] RST_VAL = {1'b0, 1'b1, {CNT_W{1'b1}}};

  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             lock_q, lock_d;

  always_comb begin
    accept = wr_en && !lock_q;
    cfg_d  = accept ? wr_data : cfg_q;
    lock_d = lock_q || wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= RST_VAL;
      lock_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      lock_q <= lock_d;
    end
  end

  assign rd_data = cfg_q;
  assign locked  = lock_q;
  assign reload  = cfg_q[CNT_W-1:0];
  assign run_en  = cfg_q[CNT_W];
  assign frz_en  = cfg_q[CNT_W+1];
endmodule

// File: rtl/wdog_svc_seq.sv
module wdog_svc_seq
  import wdog_pkg::*;
#(
  parameter int             KEY_W = SVC_W,
  parameter logic [KEY_W-1:0] KEY_A = KEY_W'(KEY_FIRST),
  parameter logic [KEY_W-1:0] KEY_B = KEY_W'(KEY_SECOND)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] data,
  output logic             hit
);
  svc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    hit     = 1'b0;
    if (wr_en) begin
      if (data == KEY_A) begin
        state_d = SVC_ARMED;
      end else begin
        hit     = (data == KEY_B) && (state_q == SVC_ARMED);
        state_d = SVC_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SVC_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  input  logic             run_en,
  input  logic             frz_en,
  input  logic             halt,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             exp_q, exp_d;
  logic             step;

  always_comb begin
    step  = tick && !(frz_en && halt);
    cnt_d = cnt_q;
    exp_d = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (!run_en) begin
      cnt_d = reload;
    end else if (step) begin
      if (cnt_q == '0) begin
        cnt_d = reload;
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expire = exp_q;
endmodule

// File: rtl/wdog_lock_top.sv
module wdog_lock_top
  import wdog_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CFG_W      = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  output logic [CFG_W-1:0] cfg_rd_data,
  input  logic             svc_wr_en,
  input  logic [SVC_W-1:0] svc_data,
  input  logic             dbg_halt,
  input  logic             tick_en,
  output logic             timeout
);
  logic             rst_sync_n;
  logic             cfg_accept, cfg_locked, run_en, frz_en, svc_hit;
  logic [CNT_W-1:0] reload, load_val;

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  wdog_cfg_reg #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .rd_data(cfg_rd_data), .accept(cfg_accept), .locked(cfg_locked),
    .reload(reload), .run_en(run_en), .frz_en(frz_en)
  );

  wdog_svc_seq u_svc (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(svc_wr_en), .data(svc_data), .hit(svc_hit)
  );

  assign load_val = cfg_accept ? cfg_wr_data[CNT_W-1:0] : reload;

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .load(cfg_accept || svc_hit),
    .load_val(load_val), .reload(reload), .run_en(run_en), .frz_en(frz_en),
    .halt(dbg_halt), .tick(tick_en), .expire(timeout)
  );
endmodule

// File: rtl/wdog_lock_chk.sv
module wdog_lock_chk #(
  parameter int CNT_W = 16,
  localparam int CFG_W = CNT_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] rd_data,
  input logic             timeout,
  input logic             tick_en,
  input logic             dbg_halt,
  input logic             locked,
  input logic             svc_hit
);
  AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> $stable(rd_data)); // R3
  AST_TO_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> $past(rd_data[CNT_W])); // R5
  AST_TO_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> $past(tick_en)); // R4
  AST_FROZEN_NO_TO: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !($past(rd_data[CNT_W+1]) && $past(dbg_halt))); // R6
  AST_SVC_NO_TO: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !$past(svc_hit)); // R8
endmodule

bind wdog_lock_top wdog_lock_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .rd_data(cfg_rd_data), .timeout(timeout),
  .tick_en(tick_en), .dbg_halt(dbg_halt), .locked(cfg_locked), .svc_hit(svc_hit)
);

// File: tb/wdog_lock_top_test.sv
module wdog_lock_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 18;

  logic          clk, rst_n, cfg_wr_en, svc_wr_en, dbg_halt, tick_en;
  logic [CW-1:0] cfg_wr_data, cfg_rd_data;
  logic [7:0]    svc_data;
  logic          timeout;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [CW-1:0] m_cfg;
  logic          m_locked, m_armed, m_to;
  logic [15:0]   m_cnt;

  wdog_lock_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .svc_wr_en(svc_wr_en), .svc_data(svc_data),
    .dbg_halt(dbg_halt), .tick_en(tick_en), .timeout(timeout)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    cfg_wr_en = 0; cfg_wr_data = '0; svc_wr_en = 0; svc_data = '0;
    dbg_halt = 0; tick_en = 0;
  endtask

  // model of one rising edge, from the requirements
  task automatic model_edge();
    logic hit, acc, step;
    m_to = 1'b0;
    acc  = cfg_wr_en && !m_locked;
    hit  = svc_wr_en && (svc_data == 8'hA5) && m_armed;                 // R8
    if (svc_wr_en) m_armed = (svc_data == 8'h5A);                       // R9
    step = tick_en && !(m_cfg[17] && dbg_halt);                         // R6 R7
    if (acc) begin
      m_cfg = cfg_wr_data; m_locked = 1'b1; m_cnt = cfg_wr_data[15:0];  // R2
    end else if (hit) begin
      m_cnt = m_cfg[15:0];
    end else if (!m_cfg[16]) begin
      m_cnt = m_cfg[15:0];                                              // R5
    end else if (step) begin
      if (m_cnt == 0) begin m_cnt = m_cfg[15:0]; m_to = 1'b1; end       // R4
      else m_cnt = m_cnt - 1'b1;
    end
    if (cfg_wr_en) m_locked = 1'b1;                                     // R3
  endtask

  task automatic step(string tag);
    model_edge();
    @(negedge clk);
    check({tag, " timeout"}, 32'(timeout), 32'(m_to));
    check({tag, " rd_data"}, 32'(cfg_rd_data), 32'(m_cfg));
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_cfg = 18'h1FFFF; m_locked = 0; m_armed = 0; m_to = 0; m_cnt = 16'hFFFF;
    check("R1 reset rd_data", 32'(cfg_rd_data), 32'h1FFFF);
    check("R1 reset timeout", 32'(timeout), 0);
  endtask

  task automatic cfg_write(string tag, logic [CW-1:0] v);
    cfg_wr_en = 1; cfg_wr_data = v;
    step(tag);
    cfg_wr_en = 0;
  endtask

  task automatic random_run(string tag, int n);
    for (int i = 0; i < n; i++) begin
      int r;
      tick_en  = ($urandom % 4) != 0;
      dbg_halt = ($urandom % 3) == 0;
      svc_wr_en = ($urandom % 5) == 0;
      r = $urandom % 4;
      svc_data = (r == 0) ? 8'h5A : (r == 1) ? 8'hA5 : (r == 2) ? 8'h5A : 8'($urandom);
      cfg_wr_en = ($urandom % 40) == 0;
      cfg_wr_data = 18'($urandom);
      step(tag);
    end
    idle_inputs();
  endtask

  task automatic service(string tag, logic [7:0] v);
    svc_wr_en = 1; svc_data = v; step(tag); svc_wr_en = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    idle_inputs();
    rst_n = 1'b0;

    // default config runs out after 65536 ticks
    do_reset();
    tick_en = 1;
    for (int i = 0; i < 65536; i++) step("R4 default");
    check("R4 default expiry seen", 32'(timeout), 1);
    step("R4 pulse ends");
    check("R4 single-cycle pulse", 32'(timeout), 0);
    idle_inputs();

    // write-once with freeze enabled
    do_reset();
    cfg_write("R2 first write", 18'h3_000A);
    check("R2 stored", 32'(cfg_rd_data), 32'h3000A);
    cfg_write("R3 second write", 18'h0_0003);
    check("R3 ignored", 32'(cfg_rd_data), 32'h3000A);
    // directed: halted ticks ignored
    tick_en = 1; dbg_halt = 1;
    for (int i = 0; i < 30; i++) step("R6 halted");
    dbg_halt = 0;
    for (int i = 0; i < 10; i++) step("R6 run");
    step("R6 expiry");
    check("R6 expiry after 11 ticks", 32'(timeout), 1);
    random_run("R6", 3000);

    // freeze disabled: halt irrelevant
    do_reset();
    cfg_write("R2 write", 18'h1_0007);
    tick_en = 1; dbg_halt = 1;
    for (int i = 0; i < 8; i++) step("R7 halt no effect");
    check("R7 expiry under halt", 32'(timeout), 1);
    random_run("R7", 3000);

    // service sequence
    do_reset();
    cfg_write("R2 write", 18'h1_0004);
    tick_en = 1;
    for (int k = 0; k < 10; k++) begin
      service("R8 key A", 8'h5A);
      step("R8 gap");
      service("R8 key B", 8'hA5);
    end
    check("R8 no expiry while serviced", 32'(timeout), 0);
    service("R9 B alone", 8'hA5);
    service("R9 A", 8'h5A);
    service("R9 wrong", 8'h33);
    service("R9 B after wrong", 8'hA5);
    step("R9 run");
    check("R9 expiry despite bad service", 32'(timeout), 1);
    random_run("R8 R9", 3000);

    // disabled
    do_reset();
    cfg_write("R2 write", 18'h0_0003);
    tick_en = 1;
    for (int i = 0; i < 20; i++) step("R5 disabled");
    check("R5 no expiry", 32'(timeout), 0);
    random_run("R5", 2000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule